// File: doc/BRIEF.md
# Tagged Rotating Operand Stack

This block is the operand store of a floating-point coprocessor datapath. It holds eight 80-bit registers, each split into a 64-bit mantissa field and a 16-bit sign-and-exponent field. Every register also carries a 2-bit tag that says what it holds: a valid number, a zero, a special value, or nothing. The stack top is a 3-bit pointer that rotates over the physical registers. No data moves between registers on a push or a pop.

Commands arrive on a valid/ready port. The commands are push, pop and replace-top. `cmd_ready` is held high, so the block never applies back-pressure. A command is taken on every clock edge where `cmd_valid` is high. The producer may change the command on any cycle.

A separate combinational read port returns ST(i), the register i places below the top, together with its tag. The pointer and the packed tag word are exposed for the status and tag registers of the coprocessor. A push onto an occupied slot, a pop of an empty top, a replace of an empty top, or a read of an empty register raises an invalid-operation flag. A faulting command leaves the block's state untouched.

Top module: `fpstk_rotstack`

## Requirements
- R1: After reset every tag is 11 (empty), `top_ptr` is 0 and all register data is zero.
- R2: A push (`cmd_op` = 01) whose target register (top-1) mod 8 is empty sets the pointer to (top-1) mod 8. It writes the target with `cmd_mant`/`cmd_sexp` and with the tag given by R5.
- R3: A pop (`cmd_op` = 10) whose top register is not empty marks that register's tag 11 and sets the pointer to (top+1) mod 8. The stored data is left as it was.
- R4: A replace-top (`cmd_op` = 11) whose top register is not empty overwrites that register's data and tag (per R5). The pointer does not change.
- R5: The written tag is 01 (zero) when sexp[14:0] and the mantissa are all zero. It is 10 (special) when sexp[14:0] is all ones, or when sexp[14:0] is nonzero and mantissa bit 63 is 0. Otherwise it is 00 (valid). Bit 15 of sexp (the sign) is ignored.
- R6: `tag_word` bits [2i+1:2i] hold the tag of physical register i, with register 7 in bits [15:14] and register 0 in bits [1:0].
- R7: The read port returns the data and tag of physical register (top + `rd_sel`) mod 8 in the same cycle. `rd_invalid` is high exactly when that tag is 11.
- R8: `op_invalid` is high, in the same cycle as the command, for a push whose target is not empty and for a pop or replace whose top is empty. Such a command changes neither the pointer, the tags nor the data.
- R9: `cmd_ready` is always 1. A cycle with `cmd_valid` low or `cmd_op` = 00 changes no state and does not raise `op_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 00 none, 01 push, 10 pop, 11 replace top |
| cmd_mant | input | 64 | Mantissa of the value to write |
| cmd_sexp | input | 16 | Sign (bit 15) and exponent (bits 14:0) of the value |
| rd_sel | input | 3 | Stack-relative index i of ST(i) |
| rd_mant | output | 64 | Mantissa of ST(i) |
| rd_sexp | output | 16 | Sign and exponent of ST(i) |
| rd_tag | output | 2 | Tag of ST(i) |
| rd_invalid | output | 1 | ST(i) is empty |
| op_invalid | output | 1 | Current command faults (stack overflow or underflow) |
| top_ptr | output | 3 | Physical index of the stack top |
| tag_word | output | 16 | Packed tags of all eight registers |

## Verification
The in-RTL assertions watch every cycle: the pointer moves by exactly one in the right direction on a good push or pop, stays put on replace and on any fault, and the tag word stays frozen when a command faults. The same assertions show that a popped slot reads back as empty and that the state after reset is empty with pointer 0. Other behaviour shows only in the bench's scenarios: the tag chosen for each class of value, the wraparound of ST(i) addressing over the register ring, the exact full and empty boundaries at eight entries, and the fact that data survives a pop. The bench covers these with a model driven by seeded random commands and directed fill-and-drain runs.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int MANT_W = 64;
  localparam int SEXP_W = 16;
  localparam int DEPTH  = 8;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_REPL = 2'b11
  } op_e;
endpackage

// File: rtl/fpstk_tagger.sv
module fpstk_tagger
  import fpstk_pkg::*;
#(
  parameter int MANT_W = fpstk_pkg::MANT_W,
  parameter int SEXP_W = fpstk_pkg::SEXP_W
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [SEXP_W-1:0] sexp,
  output logic [1:0]        tag
);
  localparam int EXP_W = SEXP_W - 1;

  logic [EXP_W-1:0] expo;
  logic exp_zero, exp_ones, mant_zero, int_bit;

  always_comb begin
    expo      = sexp[EXP_W-1:0];
    exp_zero  = (expo == '0);
    exp_ones  = (expo == '1);
    mant_zero = (mant == '0);
    int_bit   = mant[MANT_W-1];
    if (exp_zero && mant_zero)             tag = TAG_ZERO;
    else if (exp_ones)                     tag = TAG_SPECIAL;
    else if (!exp_zero && !int_bit)        tag = TAG_SPECIAL;
    else                                   tag = TAG_VALID;
  end

  // R5
  always_comb begin
    tagger_no_empty_chk: assert (tag != TAG_EMPTY);
  end
endmodule

// File: rtl/fpstk_topptr.sv
module fpstk_topptr #(
  parameter int DEPTH = fpstk_pkg::DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             inc,
  output logic [PTR_W-1:0] top
);
  always_ff @(posedge clk) begin
    if (!rst_n)   top <= '0;
    else if (dec) top <= top - PTR_W'(1);
    else if (inc) top <= top + PTR_W'(1);
  end

  // R2 R3
  ptr_one_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec, inc}));

  // R2
  ptr_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> top == $past(top) - PTR_W'(1));

  // R3
  ptr_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> top == $past(top) + PTR_W'(1));
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int MANT_W = fpstk_pkg::MANT_W,
  parameter int SEXP_W = fpstk_pkg::SEXP_W,
  parameter int DEPTH  = fpstk_pkg::DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [MANT_W-1:0]  wr_mant,
  input  logic [SEXP_W-1:0]  wr_sexp,
  input  logic [1:0]         wr_tag,
  input  logic               clr,
  input  logic [PTR_W-1:0]   clr_idx,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic [MANT_W-1:0]  rd_mant,
  output logic [SEXP_W-1:0]  rd_sexp,
  output logic [1:0]         rd_tag,
  output logic [2*DEPTH-1:0] tags
);
  logic [MANT_W-1:0] mant_q [DEPTH];
  logic [SEXP_W-1:0] sexp_q [DEPTH];
  logic [1:0]        tag_q  [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n) begin
        mant_q[k] <= '0;
        sexp_q[k] <= '0;
        tag_q[k]  <= TAG_EMPTY;
      end else if (we && wr_idx == PTR_W'(k)) begin
        mant_q[k] <= wr_mant;
        sexp_q[k] <= wr_sexp;
        tag_q[k]  <= wr_tag;
      end else if (clr && clr_idx == PTR_W'(k)) begin
        tag_q[k]  <= TAG_EMPTY;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_pack
    assign tags[2*g +: 2] = tag_q[g];
  end

  assign rd_mant = mant_q[rd_idx];
  assign rd_sexp = sexp_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];

  // R3 R4
  rf_one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && clr));

  // R3
  rf_pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tags[2*$past(clr_idx) +: 2] == TAG_EMPTY);

  // R2 R4
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> tags[2*$past(wr_idx) +: 2] == $past(wr_tag));
endmodule

// File: rtl/fpstk_rotstack.sv
module fpstk_rotstack
  import fpstk_pkg::*;
#(
  parameter int MANT_W = fpstk_pkg::MANT_W,
  parameter int SEXP_W = fpstk_pkg::SEXP_W,
  parameter int DEPTH  = fpstk_pkg::DEPTH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TW_W  = 2 * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [MANT_W-1:0] cmd_mant,
  input  logic [SEXP_W-1:0] cmd_sexp,
  input  logic [PTR_W-1:0]  rd_sel,
  output logic [MANT_W-1:0] rd_mant,
  output logic [SEXP_W-1:0] rd_sexp,
  output logic [1:0]        rd_tag,
  output logic              rd_invalid,
  output logic              op_invalid,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [TW_W-1:0]   tag_word
);
  logic [PTR_W-1:0] top, tgt, wr_idx, rd_idx;
  logic [1:0]       new_tag, tag_top, tag_tgt;
  logic push_req, pop_req, repl_req;
  logic push_bad, pop_bad, repl_bad;
  logic push_ok, pop_ok, repl_ok, we;

  assign cmd_ready = 1'b1;

  always_comb begin
    tgt      = top - PTR_W'(1);
    tag_top  = tag_word[2*top +: 2];
    tag_tgt  = tag_word[2*tgt +: 2];
    push_req = cmd_valid && (cmd_op == OP_PUSH);
    pop_req  = cmd_valid && (cmd_op == OP_POP);
    repl_req = cmd_valid && (cmd_op == OP_REPL);
    push_bad = push_req && (tag_tgt != TAG_EMPTY);
    pop_bad  = pop_req  && (tag_top == TAG_EMPTY);
    repl_bad = repl_req && (tag_top == TAG_EMPTY);
    push_ok  = push_req && !push_bad;
    pop_ok   = pop_req  && !pop_bad;
    repl_ok  = repl_req && !repl_bad;
    we       = push_ok || repl_ok;
    wr_idx   = push_ok ? tgt : top;
    rd_idx   = top + rd_sel;
    op_invalid = push_bad || pop_bad || repl_bad;
  end

  fpstk_tagger #(.MANT_W(MANT_W), .SEXP_W(SEXP_W)) u_tagger (
    .mant(cmd_mant), .sexp(cmd_sexp), .tag(new_tag)
  );

  fpstk_topptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec(push_ok), .inc(pop_ok), .top(top)
  );

  fpstk_regfile #(.MANT_W(MANT_W), .SEXP_W(SEXP_W), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(we), .wr_idx(wr_idx), .wr_mant(cmd_mant), .wr_sexp(cmd_sexp),
    .wr_tag(new_tag),
    .clr(pop_ok), .clr_idx(top),
    .rd_idx(rd_idx), .rd_mant(rd_mant), .rd_sexp(rd_sexp), .rd_tag(rd_tag),
    .tags(tag_word)
  );

  assign top_ptr    = top;
  assign rd_invalid = (rd_tag == TAG_EMPTY);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tag_word == '1) && (top_ptr == '0));

  // R8
  fault_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_invalid |=> $stable(top_ptr) && $stable(tag_word));

  // R4
  repl_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_req |=> $stable(top_ptr));

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == OP_NOP) |=> $stable(top_ptr) && $stable(tag_word));

  // R9
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !op_invalid);
endmodule

// File: tb/fpstk_rotstack_test.sv
module fpstk_rotstack_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [63:0] cmd_mant;
  logic [15:0] cmd_sexp;
  logic [2:0]  rd_sel;
  logic [63:0] rd_mant;
  logic [15:0] rd_sexp;
  logic [1:0]  rd_tag;
  logic        rd_invalid;
  logic        op_invalid;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] m_mant [8];
  logic [15:0] m_sexp [8];
  logic [1:0]  m_tag  [8];
  logic [2:0]  m_top;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpstk_rotstack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mant(cmd_mant), .cmd_sexp(cmd_sexp),
    .rd_sel(rd_sel), .rd_mant(rd_mant), .rd_sexp(rd_sexp), .rd_tag(rd_tag),
    .rd_invalid(rd_invalid), .op_invalid(op_invalid),
    .top_ptr(top_ptr), .tag_word(tag_word)
  );

  task automatic check(input bit ok, input string req,
                       input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // R5 classification, written from the requirement
  function automatic logic [1:0] want_tag(input logic [63:0] m, input logic [15:0] s);
    logic [14:0] e;
    e = s[14:0];
    if (e == 15'd0 && m == 64'd0) return 2'b01;
    if (e == 15'h7fff)            return 2'b10;
    if (e != 15'd0 && !m[63])     return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] want_word();
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = m_tag[i];
    return w;
  endfunction

  task automatic rand_value(output logic [63:0] m, output logic [15:0] s);
    int k;
    k = int'($urandom % 5);
    s = {$urandom} [15:0];
    m = {$urandom, $urandom};
    case (k)
      0: begin m = 64'd0; s[14:0] = 15'd0; end
      1: s[14:0] = 15'h7fff;
      2: begin m[63] = 1'b0; if (s[14:0] == 15'd0) s[14:0] = 15'd1; end
      3: begin m[63] = 1'b1; if (s[14:0] == 15'h7fff || s[14:0] == 15'd0) s[14:0] = 15'h3fff; end
      default: begin s[14:0] = 15'd0; if (m == 64'd0) m = 64'd5; end
    endcase
  endtask

  task automatic check_read(input logic [2:0] sel);
    logic [2:0] p;
    rd_sel = sel;
    #1;
    p = m_top + sel;
    check({rd_sexp, rd_mant} == {m_sexp[p], m_mant[p]}, "R7 data",
          {rd_sexp, rd_mant}, {m_sexp[p], m_mant[p]});
    check(rd_tag == m_tag[p], "R7 tag", 80'(rd_tag), 80'(m_tag[p]));
    check(rd_invalid == (m_tag[p] == 2'b11), "R7 rd_invalid",
          80'(rd_invalid), 80'(m_tag[p] == 2'b11));
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input bit v, input logic [1:0] op,
                      input logic [63:0] m, input logic [15:0] s);
    logic [2:0] t;
    bit   bad;
    string rq;
    cmd_valid = v; cmd_op = op; cmd_mant = m; cmd_sexp = s;
    #1;
    t   = m_top - 3'd1;
    bad = 1'b0;
    rq  = "R9 idle";
    if (v && op == 2'b01) begin bad = (m_tag[t] != 2'b11);     rq = "R8 push"; end
    if (v && op == 2'b10) begin bad = (m_tag[m_top] == 2'b11); rq = "R8 pop"; end
    if (v && op == 2'b11) begin bad = (m_tag[m_top] == 2'b11); rq = "R8 replace"; end
    check(op_invalid == bad, rq, 80'(op_invalid), 80'(bad));
    check(cmd_ready == 1'b1, "R9 ready", 80'(cmd_ready), 80'd1);
    @(posedge clk);
    if (v && !bad) begin
      case (op)
        2'b01: begin m_top = t; m_mant[t] = m; m_sexp[t] = s; m_tag[t] = want_tag(m, s); end
        2'b10: begin m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
        2'b11: begin m_mant[m_top] = m; m_sexp[m_top] = s; m_tag[m_top] = want_tag(m, s); end
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check(top_ptr == m_top, "R2 R3 top_ptr", 80'(top_ptr), 80'(m_top));
    check(tag_word == want_word(), "R5 R6 tag_word", 80'(tag_word), 80'(want_word()));
    check_read(3'($urandom % 8));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] m;
    logic [15:0] s;
    void'($urandom(32'd20231));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    cmd_mant = '0; cmd_sexp = '0; rd_sel = '0;
    for (int i = 0; i < 8; i++) begin m_mant[i] = '0; m_sexp[i] = '0; m_tag[i] = 2'b11; end
    m_top = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(tag_word == 16'hffff, "R1 tags", 80'(tag_word), 80'hffff);
    check(top_ptr == 3'd0, "R1 top", 80'(top_ptr), 80'd0);
    for (int i = 0; i < 8; i++) check_read(3'(i));

    // R8 underflow on empty stack, R4 replace on empty
    step(1'b1, 2'b10, 64'd0, 16'd0);
    step(1'b1, 2'b11, 64'h8000_0000_0000_0001, 16'h3fff);
    // R9 valid low push ignored
    step(1'b0, 2'b01, 64'h8000_0000_0000_0000, 16'h4000);
    step(1'b1, 2'b00, 64'h8000_0000_0000_0000, 16'h4000);

    // R2 fill with one of each tag class, then overflow (R8)
    step(1'b1, 2'b01, 64'd0, 16'h8000);                  // R5 zero with sign set
    step(1'b1, 2'b01, 64'h1234, 16'h7fff);               // R5 special, all-ones exp
    step(1'b1, 2'b01, 64'h7fff_ffff_ffff_ffff, 16'h0001);// R5 special, integer bit clear
    step(1'b1, 2'b01, 64'h0000_0000_0000_0001, 16'h0000);// R5 denormal is valid
    step(1'b1, 2'b01, 64'h8000_0000_0000_0000, 16'hbfff);// R5 valid
    for (int i = 0; i < 3; i++) step(1'b1, 2'b01, 64'hc000_0000_0000_0000 + 64'(i), 16'h4001);
    for (int i = 0; i < 8; i++) check_read(3'(i));
    step(1'b1, 2'b01, 64'hdead_beef_0000_0000, 16'h4002); // R8 overflow
    step(1'b1, 2'b11, 64'd0, 16'd0);                     // R4 replace top
    // R3 drain then underflow
    for (int i = 0; i < 8; i++) step(1'b1, 2'b10, 64'd0, 16'd0);
    step(1'b1, 2'b10, 64'd0, 16'd0);
    for (int i = 0; i < 8; i++) check_read(3'(i));        // R3 data survives pop

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom % 10);
      rand_value(m, s);
      if (r < 4)       step(1'b1, 2'b01, m, s);
      else if (r < 7)  step(1'b1, 2'b10, m, s);
      else if (r < 9)  step(1'b1, 2'b11, m, s);
      else             step(($urandom % 2) == 0, 2'b00 | 2'($urandom % 4), m, s);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule